// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a two-level page table held in memory. A caller offers the logical address together with the current page-table base pointer through a valid/ready handshake. The walker then performs two dependent reads through a single request/response memory read port: first an entry of the outer table, then an entry of the inner table page that the outer entry points to. When the walk ends it raises a one-cycle done pulse carrying either the physical address or a page fault tagged with the level that failed.

The logical address splits into a 12-bit outer index (bits 31:20), a 10-bit inner index (bits 19:10) and a 10-bit page offset (bits 9:0), giving 1 KB pages. Every table entry is one 32-bit word. Bit 0 of an entry is its valid flag. Bits 31:10 hold a 1 KB-aligned base. Bits 9:1 carry no meaning for the walker. The memory port may stall a request and may answer after any number of cycles, and only one read is ever outstanding.

The controller moves through six named states. IDLE waits for a request. READ_OUTER issues the outer read, and WAIT_OUTER waits for its data. READ_INNER issues the inner read, and WAIT_INNER waits for its data. DONE presents the result. The transitions are as follows:
- IDLE to READ_OUTER on an accepted request.
- READ_OUTER to WAIT_OUTER, and READ_INNER to WAIT_INNER, when the memory accepts the read.
- WAIT_OUTER to READ_INNER on a valid outer entry.
- WAIT_OUTER to DONE on an invalid outer entry.
- WAIT_INNER to DONE on any inner response.
- DONE to IDLE unconditionally.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1, while done and mem_req_valid are 0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1, and req_vaddr and ptbr are captured on that edge. From the next cycle req_ready stays 0 until the cycle after done. Later changes on req_vaddr, ptbr or req_valid do not affect the walk in progress.
- R3: The first read goes to ptbr + 4 * req_vaddr[31:20].
- R4: The second read goes to {outer_entry[31:10], 10'b0} + 4 * req_vaddr[19:10].
- R5: A read request holds mem_req_valid and a stable mem_req_addr until mem_req_ready is seen. The walker then waits any number of cycles for mem_rsp_valid, with at most one read outstanding.
- R6: When both entries have bit 0 set, the result is done_fault = 0 and done_paddr = {inner_entry[31:10], req_vaddr[9:0]}. Entry bits 9:1 have no effect.
- R7: An outer entry with bit 0 clear gives done_fault = 1, done_fault_level = 0 (outer) and done_paddr = 0, and no second read is issued.
- R8: An inner entry with bit 0 clear gives done_fault = 1, done_fault_level = 1 (inner) and done_paddr = 0.
- R9: done is high for exactly one cycle per accepted request. In the following cycle req_ready is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translate request offered |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | ADDR_W | Logical address to translate |
| ptbr | input | ADDR_W | Byte address of the outer table |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | ADDR_W | Byte address of the table entry to read |
| mem_rsp_valid | input | 1 | Read data returned (one-cycle pulse) |
| mem_rsp_data | input | ADDR_W | Table entry read from memory |
| done | output | 1 | One-cycle pulse: walk finished |
| done_paddr | output | ADDR_W | Physical address, zero on a fault |
| done_fault | output | 1 | Page fault flag |
| done_fault_level | output | 1 | Failing level: 0 outer, 1 inner |

## Verification
The bench builds the walker with its default parameters: a 32-bit address, a 10-bit inner index and a 10-bit offset, which leaves a 12-bit outer index. With these values the largest outer index (byte offset 0x3FFC from the base) and the largest inner index and offset are reachable with all-ones addresses. The memory model inside the bench adds chosen stall and response delays, so the walker's hold and wait behaviour is exercised alongside zero-delay replies. Entries that carry stray flag bits, and entries whose base bits are set while bit 0 is clear, show that only bit 0 decides validity.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_OUTER,
        ST_WAIT_OUTER,
        ST_READ_INNER,
        ST_WAIT_INNER,
        ST_DONE
    } walk_state_t;

    typedef enum logic {
        LVL_OUTER = 1'b0,
        LVL_INNER = 1'b1
    } walk_level_t;

    localparam int ENTRY_BYTES_LOG2 = 2;

endpackage

// File: rtl/ptw_index_addr.sv
module ptw_index_addr #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10
) (
    input  logic [ADDR_W-1:0] table_base,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] entry_addr
);
    import ptw_pkg::*;

    localparam int PAD_W = ADDR_W - IDX_W - ENTRY_BYTES_LOG2;

    // each entry occupies one word, so the byte offset is the index scaled by 4
    assign entry_addr = table_base
                      + {{PAD_W{1'b0}}, index, {ENTRY_BYTES_LOG2{1'b0}}};

endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 10
) (
    input  logic [ADDR_W-1:0] entry,
    output logic              entry_ok,
    output logic [ADDR_W-1:0] frame_base
);
    logic unused_flag_bits;

    assign entry_ok         = entry[0];
    assign frame_base       = {entry[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};
    assign unused_flag_bits = ^entry[OFFS_W-1:1];

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int ADDR_W  = 32,
    parameter int INNER_W = 10,
    parameter int OFFS_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] ptbr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              done,
    output logic [ADDR_W-1:0] done_paddr,
    output logic              done_fault,
    output logic              done_fault_level
);
    import ptw_pkg::*;

    localparam int OUTER_W  = ADDR_W - INNER_W - OFFS_W;
    localparam int OUTER_LO = INNER_W + OFFS_W;

    walk_state_t state_q, state_d;

    logic [ADDR_W-1:0] vaddr_q;
    logic [ADDR_W-1:0] ptbr_q;
    logic [ADDR_W-1:0] inner_base_q;
    logic [ADDR_W-1:0] paddr_q;
    logic              fault_q;
    walk_level_t       level_q;

    logic [OUTER_W-1:0] outer_idx;
    logic [INNER_W-1:0] inner_idx;
    logic [OFFS_W-1:0]  page_offs;
    logic [ADDR_W-1:0]  outer_addr;
    logic [ADDR_W-1:0]  inner_addr;
    logic               rsp_entry_ok;
    logic [ADDR_W-1:0]  rsp_frame;

    assign outer_idx = vaddr_q[ADDR_W-1:OUTER_LO];
    assign inner_idx = vaddr_q[OUTER_LO-1:OFFS_W];
    assign page_offs = vaddr_q[OFFS_W-1:0];

    ptw_index_addr #(.ADDR_W(ADDR_W), .IDX_W(OUTER_W)) u_outer_addr (
        .table_base (ptbr_q),
        .index      (outer_idx),
        .entry_addr (outer_addr)
    );

    ptw_index_addr #(.ADDR_W(ADDR_W), .IDX_W(INNER_W)) u_inner_addr (
        .table_base (inner_base_q),
        .index      (inner_idx),
        .entry_addr (inner_addr)
    );

    // one decoder serves both levels: only one response is ever in flight
    ptw_entry_decode #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_decode (
        .entry      (mem_rsp_data),
        .entry_ok   (rsp_entry_ok),
        .frame_base (rsp_frame)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_valid)     state_d = ST_READ_OUTER;
            ST_READ_OUTER: if (mem_req_ready) state_d = ST_WAIT_OUTER;
            ST_WAIT_OUTER: if (mem_rsp_valid) state_d = rsp_entry_ok ? ST_READ_INNER : ST_DONE;
            ST_READ_INNER: if (mem_req_ready) state_d = ST_WAIT_INNER;
            ST_WAIT_INNER: if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE:                          state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    // walk context and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q      <= '0;
            ptbr_q       <= '0;
            inner_base_q <= '0;
            paddr_q      <= '0;
            fault_q      <= 1'b0;
            level_q      <= LVL_OUTER;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                vaddr_q <= req_vaddr;
                ptbr_q  <= ptbr;
                paddr_q <= '0;
                fault_q <= 1'b0;
                level_q <= LVL_OUTER;
            end
            if (state_q == ST_WAIT_OUTER && mem_rsp_valid) begin
                if (rsp_entry_ok) begin
                    inner_base_q <= rsp_frame;
                end else begin
                    fault_q <= 1'b1;
                    level_q <= LVL_OUTER;
                end
            end
            if (state_q == ST_WAIT_INNER && mem_rsp_valid) begin
                if (rsp_entry_ok) begin
                    paddr_q <= rsp_frame | {{(ADDR_W-OFFS_W){1'b0}}, page_offs};
                end else begin
                    paddr_q <= '0;
                    fault_q <= 1'b1;
                    level_q <= LVL_INNER;
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_READ_OUTER) || (state_q == ST_READ_INNER);
        mem_req_addr  = (state_q == ST_READ_INNER) ? inner_addr : outer_addr;
        done          = (state_q == ST_DONE);
        done_paddr    = paddr_q;
        done_fault    = fault_q;
        done_fault_level = (level_q == LVL_INNER);
    end

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              done,
    input logic [ADDR_W-1:0] done_paddr,
    input logic              done_fault,
    input logic              done_fault_level
);

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_one_outstanding_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    assert_outer_fault_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault && !done_fault_level) |-> (done_paddr == '0));

    assert_inner_fault_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault && done_fault_level) |-> (done_paddr == '0));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    assert_done_not_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!req_ready && !mem_req_valid && !mem_rsp_valid));

endmodule

bind pt_walker ptw_checker #(.ADDR_W(ADDR_W)) u_ptw_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_ready        (req_ready),
    .mem_req_valid    (mem_req_valid),
    .mem_req_ready    (mem_req_ready),
    .mem_req_addr     (mem_req_addr),
    .mem_rsp_valid    (mem_rsp_valid),
    .done             (done),
    .done_paddr       (done_paddr),
    .done_fault       (done_fault),
    .done_fault_level (done_fault_level)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] ptbr = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic [31:0] done_paddr;
    logic        done_fault;
    logic        done_fault_level;

    always #2.5 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .ptbr(ptbr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .done_paddr(done_paddr),
        .done_fault(done_fault), .done_fault_level(done_fault_level)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // memory model state
    logic [31:0] mem_img [logic [31:0]];
    int          cfg_lat   = 0;
    int          cfg_stall = 0;
    int          lat_left  = 0;
    int          stall_left = 0;
    bit          mem_busy  = 1'b0;
    logic [31:0] pend_addr = '0;
    int          reads_seen = 0;
    logic [31:0] rd_log [0:3];

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        if (mem_img.exists(a)) return mem_img[a];
        return 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // memory responder, updated away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            mem_busy      = 1'b0;
            stall_left    = cfg_stall;
        end else begin
            mem_rsp_valid = 1'b0;
            if (mem_busy) begin
                mem_req_ready = 1'b0;
                if (lat_left == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_rd(pend_addr);
                    mem_busy      = 1'b0;
                    stall_left    = cfg_stall;
                end else begin
                    lat_left--;
                end
            end else if (mem_req_valid) begin
                if (stall_left > 0) begin
                    stall_left--;
                    mem_req_ready = 1'b0;
                end else begin
                    mem_req_ready = 1'b1;
                    mem_busy      = 1'b1;
                    lat_left      = cfg_lat;
                    pend_addr     = mem_req_addr;
                    if (reads_seen < 4) rd_log[reads_seen] = mem_req_addr;
                    reads_seen++;
                end
            end else begin
                mem_req_ready = 1'b0;
            end
        end
    end

    // one walk: install entries, compute expectations from the requirements, run, check
    task automatic walk_case(input logic [31:0] va, input logic [31:0] base,
                             input logic [31:0] outer_e, input logic [31:0] inner_e,
                             input bit hold_req, input string tag);
        logic [31:0] a0, a1, exp_pa;
        bit          exp_fault, exp_lvl;
        int          exp_reads, wait_cnt;
        bool_dummy: begin end
        a0 = base + {18'h0, va[31:20], 2'b00};
        a1 = (outer_e & 32'hFFFF_FC00) + {20'h0, va[19:10], 2'b00};
        mem_img[a0] = outer_e;
        mem_img[a1] = inner_e;
        if (!outer_e[0]) begin
            exp_fault = 1'b1; exp_lvl = 1'b0; exp_pa = 32'h0; exp_reads = 1;
        end else if (!inner_e[0]) begin
            exp_fault = 1'b1; exp_lvl = 1'b1; exp_pa = 32'h0; exp_reads = 2;
        end else begin
            exp_fault = 1'b0; exp_lvl = 1'b0;
            exp_pa = (inner_e & 32'hFFFF_FC00) | {22'h0, va[9:0]};
            exp_reads = 2;
        end
        reads_seen = 0;
        @(negedge clk);
        req_vaddr = va;
        ptbr      = base;
        req_valid = 1'b1;
        chk(req_ready == 1'b1, "R2", {tag, " ready before accept"}, {31'h0, req_ready}, 32'h1);
        @(negedge clk);
        // scramble the inputs after acceptance: the walk must not see them
        req_vaddr = ~va;
        ptbr      = base ^ 32'h5A5A_0000;
        req_valid = hold_req;
        chk(req_ready == 1'b0, "R2", {tag, " busy after accept"}, {31'h0, req_ready}, 32'h0);
        wait_cnt = 0;
        while (!done && wait_cnt < 500) begin
            @(negedge clk);
            wait_cnt++;
        end
        chk(done == 1'b1, "R9", {tag, " done reached"}, {31'h0, done}, 32'h1);
        chk(done_fault == exp_fault, exp_fault ? (exp_lvl ? "R8" : "R7") : "R6",
            {tag, " fault flag"}, {31'h0, done_fault}, {31'h0, exp_fault});
        if (exp_fault)
            chk(done_fault_level == exp_lvl, exp_lvl ? "R8" : "R7",
                {tag, " fault level"}, {31'h0, done_fault_level}, {31'h0, exp_lvl});
        chk(done_paddr == exp_pa, exp_fault ? (exp_lvl ? "R8" : "R7") : "R6",
            {tag, " physical address"}, done_paddr, exp_pa);
        chk(reads_seen == exp_reads, exp_reads == 1 ? "R7" : "R5",
            {tag, " read count"}, reads_seen, exp_reads);
        chk(rd_log[0] == a0, "R3", {tag, " outer entry address"}, rd_log[0], a0);
        if (exp_reads == 2)
            chk(rd_log[1] == a1, "R4", {tag, " inner entry address"}, rd_log[1], a1);
        req_valid = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R9", {tag, " done single pulse"}, {31'h0, done}, 32'h0);
        chk(req_ready == 1'b1, "R9", {tag, " ready after done"}, {31'h0, req_ready}, 32'h1);
    endtask

    task automatic test_reset;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready in reset", {31'h0, req_ready}, 32'h1);
        chk(done == 1'b0, "R1", "done in reset", {31'h0, done}, 32'h0);
        chk(mem_req_valid == 1'b0, "R1", "mem request in reset", {31'h0, mem_req_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && done == 1'b0 && mem_req_valid == 1'b0, "R1",
            "state after reset", {29'h0, req_ready, done, mem_req_valid}, 32'h4);
    endtask

    task automatic test_basic_map;
        cfg_lat = 0; cfg_stall = 0;
        // inner entry carries stray flag bits 9:1 (R6)
        walk_case(32'h1236_AD55, 32'h0010_0000, 32'h0040_0001, 32'h1234_5DFF, 1'b0, "basic");
        walk_case(32'h0000_0000, 32'h0000_1000, 32'h0070_0003, 32'h0900_0001, 1'b0, "zero index");
    endtask

    task automatic test_slow_memory;
        cfg_lat = 5; cfg_stall = 3;
        walk_case(32'hFFFF_FFFF, 32'h0020_0000, 32'h0080_0001, 32'hABCD_E401, 1'b0, "slow max index");
        cfg_lat = 2; cfg_stall = 0;
        walk_case(32'h0015_0A0F, 32'h0030_0000, 32'h0100_0401, 32'h7777_7C01, 1'b0, "latency only");
    endtask

    task automatic test_outer_fault;
        cfg_lat = 1; cfg_stall = 1;
        // base bits set but valid bit clear (R7)
        walk_case(32'h0A00_1234, 32'h0040_0000, 32'h0050_03FE, 32'h1111_1001, 1'b0, "outer invalid");
    endtask

    task automatic test_inner_fault;
        cfg_lat = 0; cfg_stall = 2;
        walk_case(32'h0B10_2345, 32'h0060_0000, 32'h0090_0001, 32'hFFFF_FFFE, 1'b0, "inner invalid");
    endtask

    task automatic test_busy_ignore;
        cfg_lat = 3; cfg_stall = 1;
        // req_valid kept high with a different address for the whole walk (R2)
        walk_case(32'h0C20_3456, 32'h0070_0000, 32'h00A0_0001, 32'h4444_4801, 1'b1, "held request");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        test_reset;
        test_basic_map;
        test_slow_memory;
        test_outer_fault;
        test_inner_fault;
        test_busy_ignore;
        repeat (3) @(negedge clk);
        summary;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary;
        $finish;
    end

endmodule